// File: doc/BRIEF.md
# ALU with Condition Codes and Branch Test

This block is the integer execute stage of a small teaching processor. A combinational arithmetic/logic unit takes two register operands, called rA and rB, and a 4-bit function code. It produces one of four results: the sum, the difference rB minus rA, the bitwise AND, or the bitwise XOR. The same stage holds three condition flags in a register: zero, negative and signed overflow. The flags are loaded from the unit's result on a rising clock edge, and only while the update enable is high.

A separate 4-bit jump code is tested against the stored flags, not against the current result. The test gives one taken bit. A branch instruction therefore sees the flags left by the last flag-setting arithmetic or logical operation.

Function codes that are not defined give a zero result and a low valid bit. Jump codes that are not defined are never taken. A synchronous reset sets the flags to the state of a zero result.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn`=0 the result is `op_b + op_a`. With `alu_fn`=1 it is `op_b - op_a`. Both wrap modulo 2^DATA_W, and the result is combinational.
- R2: With `alu_fn`=2 the result is `op_a & op_b`. With `alu_fn`=3 it is `op_a ^ op_b`.
- R3: Any `alu_fn` from 4 to 15 drives `result` to 0 and `fn_valid` to 0. Such a code leaves all three flags unchanged, even with `set_cc` high. For codes 0 to 3, `fn_valid` is 1.
- R4: On a rising edge with `set_cc`=1 and a valid function, `flag_zf` loads (result == 0) and `flag_sf` loads the result's top bit.
- R5: For an add, `flag_of` loads 1 exactly when both operands have the same sign and the sum's sign differs from it.
- R6: For a subtract, `flag_of` loads 1 exactly when `op_b` and `op_a` have different signs and the difference's sign differs from `op_b`'s sign.
- R7: AND and XOR load `flag_of` with 0.
- R8: On an edge with `set_cc`=0, all three flags keep their values.
- R9: A rising edge with `rst`=1 sets `flag_zf`=1, `flag_sf`=0 and `flag_of`=0. Reset takes priority over `set_cc`.
- R10: `jmp_taken` depends on `jmp_fn` and the stored flags, with lt = SF xor OF:
  - 0: always taken
  - 1: lt or ZF
  - 2: lt
  - 3: ZF
  - 4: not ZF
  - 5: not lt
  - 6: not lt and not ZF
- R11: Any `jmp_fn` from 7 to 15 gives `jmp_taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the flags, active high |
| alu_fn | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| op_a | input | DATA_W | First operand (rA) |
| op_b | input | DATA_W | Second operand (rB); the minuend of a subtract |
| set_cc | input | 1 | Loads the flags from this cycle's operation |
| jmp_fn | input | 4 | Jump condition select |
| result | output | DATA_W | Combinational result of the unit |
| fn_valid | output | 1 | High when `alu_fn` is a defined code |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored signed overflow flag |
| jmp_taken | output | 1 | Jump condition met on the stored flags |

## Verification
The assertions assume that `alu_fn`, `set_cc` and `jmp_fn` are known values at every sampled edge outside reset. They also assume that the inputs stay constant through the clock edge at which the flags load. The stimulus changes all inputs only on falling edges, which keeps within both assumptions. Random function codes are biased toward the four defined codes but still reach the undefined ones. Operands are sometimes drawn from extreme and equal values, so that zero results and both overflow directions occur. Random jump codes cover all sixteen values against whatever flag state the previous operations left.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
   localparam int unsigned FN_W = 4;

   localparam logic [FN_W-1:0] OP_ADD = 4'd0;
   localparam logic [FN_W-1:0] OP_SUB = 4'd1;
   localparam logic [FN_W-1:0] OP_AND = 4'd2;
   localparam logic [FN_W-1:0] OP_XOR = 4'd3;

   localparam logic [FN_W-1:0] BR_ALWAYS = 4'd0;
   localparam logic [FN_W-1:0] BR_LE     = 4'd1;
   localparam logic [FN_W-1:0] BR_LT     = 4'd2;
   localparam logic [FN_W-1:0] BR_EQ     = 4'd3;
   localparam logic [FN_W-1:0] BR_NE     = 4'd4;
   localparam logic [FN_W-1:0] BR_GE     = 4'd5;
   localparam logic [FN_W-1:0] BR_GT     = 4'd6;

   typedef struct packed {
      logic zf;
      logic sf;
      logic of;
   } cc_flags_t;

   localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_core.sv
module alu_core
   import alu_cc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SHARED_ADD = 1'b1
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output logic              valid,
   output cc_flags_t         next_cc
);
   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu_core: DATA_W must be at least 2");
      end
   endgenerate

   logic              is_sub;
   logic [DATA_W-1:0] arith;
   logic              arith_of;

   assign is_sub = (fn == OP_SUB);

   generate
      if (SHARED_ADD) begin : g_shared
         logic [DATA_W-1:0] addend;
         assign addend   = is_sub ? ~a : a;
         assign arith    = b + addend + {{(DATA_W-1){1'b0}}, is_sub};
         assign arith_of = (b[MSB] == addend[MSB]) && (arith[MSB] != b[MSB]);
      end else begin : g_split
         logic [DATA_W-1:0] sum_v;
         logic [DATA_W-1:0] dif_v;
         logic              sum_of;
         logic              dif_of;
         assign sum_v    = b + a;
         assign dif_v    = b - a;
         assign sum_of   = (a[MSB] == b[MSB]) && (sum_v[MSB] != a[MSB]);
         assign dif_of   = (a[MSB] != b[MSB]) && (dif_v[MSB] != b[MSB]);
         assign arith    = is_sub ? dif_v : sum_v;
         assign arith_of = is_sub ? dif_of : sum_of;
      end
   endgenerate

   always_comb begin
      y     = '0;
      valid = 1'b1;
      next_cc.of = 1'b0;
      case (fn)
         OP_ADD, OP_SUB: begin
            y          = arith;
            next_cc.of = arith_of;
         end
         OP_AND: y = a & b;
         OP_XOR: y = a ^ b;
         default: valid = 1'b0;
      endcase
      next_cc.zf = (y == '0);
      next_cc.sf = y[MSB];
   end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
   import alu_cc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      load,
   input  cc_flags_t d,
   output cc_flags_t q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= CC_RESET;
      else if (load) q <= d;
   end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
   import alu_cc_pkg::*;
(
   input  logic [FN_W-1:0] cond,
   input  cc_flags_t       cc,
   output logic            taken
);
   logic less;
   assign less = cc.sf ^ cc.of;

   always_comb begin
      case (cond)
         BR_ALWAYS: taken = 1'b1;
         BR_LE:     taken = less | cc.zf;
         BR_LT:     taken = less;
         BR_EQ:     taken = cc.zf;
         BR_NE:     taken = ~cc.zf;
         BR_GE:     taken = ~less;
         BR_GT:     taken = ~less & ~cc.zf;
         default:   taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
   import alu_cc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SHARED_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        alu_fn,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              set_cc,
   input  logic [3:0]        jmp_fn,
   output logic [DATA_W-1:0] result,
   output logic              fn_valid,
   output logic              flag_zf,
   output logic              flag_sf,
   output logic              flag_of,
   output logic              jmp_taken
);
   cc_flags_t cc_d;
   cc_flags_t cc_q;

   alu_core #(.DATA_W(DATA_W), .SHARED_ADD(SHARED_ADD)) u_core (
      .fn      (alu_fn),
      .a       (op_a),
      .b       (op_b),
      .y       (result),
      .valid   (fn_valid),
      .next_cc (cc_d)
   );

   cc_reg u_cc (
      .clk  (clk),
      .rst  (rst),
      .load (set_cc & fn_valid),
      .d    (cc_d),
      .q    (cc_q)
   );

   branch_eval u_br (
      .cond  (jmp_fn),
      .cc    (cc_q),
      .taken (jmp_taken)
   );

   assign flag_zf = cc_q.zf;
   assign flag_sf = cc_q.sf;
   assign flag_of = cc_q.of;
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        alu_fn,
   input logic              set_cc,
   input logic [3:0]        jmp_fn,
   input logic [DATA_W-1:0] result,
   input logic              fn_valid,
   input logic              flag_zf,
   input logic              flag_sf,
   input logic              flag_of,
   input logic              jmp_taken
);
   AST_RESET_FLAGS: assert property (@(posedge clk) rst |=> (flag_zf && !flag_sf && !flag_of)); // R9
   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst) (alu_fn > 4'd3) |-> (!fn_valid && result == '0)); // R3
   AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst) !fn_valid |=> $stable({flag_zf, flag_sf, flag_of})); // R3
   AST_NO_SET_HOLD: assert property (@(posedge clk) disable iff (rst) !set_cc |=> $stable({flag_zf, flag_sf, flag_of})); // R8
   AST_ZF_LOAD: assert property (@(posedge clk) disable iff (rst) (set_cc && fn_valid) |=> (flag_zf == ($past(result) == '0))); // R4
   AST_SF_LOAD: assert property (@(posedge clk) disable iff (rst) (set_cc && fn_valid) |=> (flag_sf == $past(result[DATA_W-1]))); // R4
   AST_LOGIC_NO_OF: assert property (@(posedge clk) disable iff (rst) (set_cc && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !flag_of); // R7
   AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (rst) (jmp_fn == 4'd0) |-> jmp_taken); // R10
   AST_JMP_EQ: assert property (@(posedge clk) disable iff (rst) (jmp_fn == 4'd3) |-> (jmp_taken == flag_zf)); // R10
   AST_JMP_UNUSED: assert property (@(posedge clk) disable iff (rst) (jmp_fn > 4'd6) |-> !jmp_taken); // R11
endmodule

bind alu_cc_unit alu_cc_chk #(.DATA_W(DATA_W)) u_alu_cc_chk (
   .clk       (clk),
   .rst       (rst),
   .alu_fn    (alu_fn),
   .set_cc    (set_cc),
   .jmp_fn    (jmp_fn),
   .result    (result),
   .fn_valid  (fn_valid),
   .flag_zf   (flag_zf),
   .flag_sf   (flag_sf),
   .flag_of   (flag_of),
   .jmp_taken (jmp_taken)
);

// File: tb/test_alu_cc_unit.sv
module test_alu_cc_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic [3:0]   alu_fn;
   logic [W-1:0] op_a;
   logic [W-1:0] op_b;
   logic         set_cc;
   logic [3:0]   jmp_fn;
   logic [W-1:0] result;
   logic         fn_valid;
   logic         flag_zf;
   logic         flag_sf;
   logic         flag_of;
   logic         jmp_taken;

   int errors = 0;
   int checks = 0;
   logic m_zf, m_sf, m_of;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_cc_unit #(.DATA_W(W)) i_alu_cc_unit (
      .clk(clk), .rst(rst), .alu_fn(alu_fn), .op_a(op_a), .op_b(op_b),
      .set_cc(set_cc), .jmp_fn(jmp_fn), .result(result), .fn_valid(fn_valid),
      .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of), .jmp_taken(jmp_taken)
   );

   function automatic logic [W-1:0] ref_result(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
      case (f)
         4'd0: return b + a;
         4'd1: return b - a;
         4'd2: return a & b;
         4'd3: return a ^ b;
         default: return '0;
      endcase
   endfunction

   function automatic logic ref_of(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [W:0] wide;
      if (f == 4'd0) wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
      else if (f == 4'd1) wide = $signed({b[W-1], b}) - $signed({a[W-1], a});
      else return 1'b0;
      return wide[W] != wide[W-1];
   endfunction

   function automatic logic ref_taken(input logic [3:0] j, input logic z, input logic s, input logic o);
      logic lt;
      lt = (s != o);
      if (j == 4'd0) return 1'b1;
      if (j == 4'd1) return lt || z;
      if (j == 4'd2) return lt;
      if (j == 4'd3) return z;
      if (j == 4'd4) return !z;
      if (j == 4'd5) return !lt;
      if (j == 4'd6) return !lt && !z;
      return 1'b0;
   endfunction

   task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_flags(input string req);
      check({flag_zf, flag_sf, flag_of} == {m_zf, m_sf, m_of}, req,
            {29'd0, flag_zf, flag_sf, flag_of}, {29'd0, m_zf, m_sf, m_of});
   endtask

   task automatic do_op(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sc, input logic [3:0] j);
      logic [W-1:0] er;
      logic         ev;
      @(negedge clk);
      alu_fn = f; op_a = a; op_b = b; set_cc = sc; jmp_fn = j;
      #1;
      er = ref_result(f, a, b);
      ev = (f <= 4'd3);
      if (f < 4'd2) check(result == er, "R1", result, er);
      else if (f < 4'd4) check(result == er, "R2", result, er);
      else check(result == '0 && !fn_valid, "R3", {result[W-2:0], fn_valid}, '0);
      if (ev) check(fn_valid, "R3", {31'd0, fn_valid}, 1);
      if (j > 4'd6) check(jmp_taken == 1'b0, "R11", {31'd0, jmp_taken}, 0);
      else check(jmp_taken == ref_taken(j, m_zf, m_sf, m_of), "R10",
                 {31'd0, jmp_taken}, {31'd0, ref_taken(j, m_zf, m_sf, m_of)});
      @(posedge clk);
      if (sc && ev) begin
         m_zf = (er == '0);
         m_sf = er[W-1];
         m_of = ref_of(f, a, b);
      end
      #1;
      if (!ev) check_flags("R3");
      else if (!sc) check_flags("R8");
      else if (f == 4'd0) check_flags("R5");
      else if (f == 4'd1) check_flags("R6");
      else check_flags("R7");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; set_cc = 1'b1; alu_fn = 4'd0; op_a = 32'd1; op_b = 32'hFFFF_FFF0;
      @(posedge clk);
      #1;
      m_zf = 1'b1; m_sf = 1'b0; m_of = 1'b0;
      check_flags("R9");
      @(negedge clk);
      rst = 1'b0; set_cc = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0B1E));
      rst = 1'b1; alu_fn = 4'd0; op_a = '0; op_b = '0; set_cc = 1'b0; jmp_fn = 4'd0;
      m_zf = 1'b1; m_sf = 1'b0; m_of = 1'b0;
      do_reset();

      // directed corners
      do_op(4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 4'd2); // R5 positive overflow
      do_op(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'd2); // R5 zero with overflow
      do_op(4'd1, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'd3); // R6 b minus a overflows
      do_op(4'd1, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd1); // R6 equal -> ZF
      do_op(4'd1, 32'h0000_0005, 32'h0000_0003, 1'b1, 4'd6); // R1 3-5 negative
      do_op(4'd2, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1, 4'd4); // R7 AND zero
      do_op(4'd3, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 4'd5); // R7 XOR negative
      do_op(4'd7, 32'h0000_0001, 32'h0000_0002, 1'b1, 4'd9); // R3 invalid with set_cc
      do_op(4'd0, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd3); // R8 no update
      for (int j = 0; j < 16; j++) do_op(4'd15, 32'd0, 32'd0, 1'b0, j[3:0]); // R10 R11 sweep
      do_reset(); // R9 again after flags changed

      for (int i = 0; i < 600; i++) begin
         logic [3:0]   f;
         logic [W-1:0] a, b;
         int sel;
         f = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 3)) : 4'($urandom_range(4, 15));
         sel = $urandom_range(0, 5);
         a = $urandom();
         b = $urandom();
         if (sel == 0) b = a;
         else if (sel == 1) begin a = {$urandom_range(0, 1) ? 1'b1 : 1'b0, 31'h7FFF_FFFF}; b = 32'h7FFF_FFF0; end
         else if (sel == 2) begin a = 32'h8000_0000 + $urandom_range(0, 3); b = 32'h8000_0000; end
         do_op(f, a, b, ($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule